// File: doc/BRIEF.md
# Dual-Buffer Channel Register Bank

This block holds the settings for a bank of converter channels. It accepts one validated 24-bit command word per clock, qualified by `cmd_valid`. It decides whether the word is addressed to this bank and updates a pair of 18-bit registers in each of four channels.

The first register of each pair is a staging register. The second is the live register that drives the outputs. Each live register splits into a 16-bit code and a 2-bit power-down mode. Power-down settings travel through the same two stages as ordinary codes, so they can be staged, applied to one channel, or applied to every channel at once.

A separate load input moves every staged value to the live side on its rising edge. This lets several banks that share one command stream switch their outputs together.

Top module: `dbuf_chan_bank`

## Requirements
- R1: After reset, every channel shows code 0, power-down mode 00 and `ch_off` low.
- R2: A command is ignored unless bits [23:22] equal `addr_strap[1:0]` (bit 23 against `addr_strap[1]`). The exception is load mode 11, which is accepted whatever the address bits hold.
- R3: Load mode 00 (bits [21:20]) writes the staging register of the channel chosen by bits [18:17] and leaves every live register unchanged.
- R4: Load mode 01 writes both the staging and the live register of the chosen channel. The new value is visible on the outputs in the cycle after the command is presented.
- R5: Load mode 10 writes both registers of the chosen channel. In the same cycle, every other channel moves its staging value to its live register.
- R6: Load mode 11 with bit 18 low moves every channel's staging value to its live register, regardless of the address bits.
- R7: Load mode 11 with bit 18 high writes the new word into both registers of every channel, regardless of the address bits.
- R8: With bit 16 high, the power-down field takes bits [15:14], where 01 is a 1 kΩ pull to ground, 10 is 100 kΩ, and 11 is high impedance. A request with bits [15:14] = 00 is stored as 11. The code field always takes bits [15:0]. `ch_off` is high exactly when the live power-down field is non-zero.
- R9: With bit 16 low, the power-down field is stored as 00, so the channel runs normally.
- R10: A rising edge on `hw_load` moves every staging value to its live register once. Holding `hw_load` high causes no further transfer.
- R11: When a command and a `hw_load` rising edge land in the same cycle, a channel whose live register the command writes from the new word takes that word. Every other channel's live register takes its staging value as it stood before that cycle.
- R12: Bit 19 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 2 | Bank address compared with command bits [23:22] |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 24 | Command word |
| hw_load | input | 1 | Edge-sensitive transfer of all staging values |
| ch_code | output | 64 | Live codes, channel n at bits [16n+15:16n] |
| ch_pdmode | output | 8 | Live power-down modes, channel n at bits [2n+1:2n] |
| ch_off | output | 4 | Channel n is powered down |

## Verification
The bench sweeps every combination of strap, address bits, load mode and channel. It crosses these with three power-down variants, and in some cycles adds a coinciding `hw_load` edge. The staging contents only become visible through later transfers, so a design that writes the live register during a store, or that copies the wrong channel during a simultaneous update, shows up as a wrong code some commands later. Broadcasts carry a mismatched address to catch a decoder that lets address checking block them. A power-down request with mode bits 00 is checked to come out as a powered-down channel, not a normal one. A held-high `hw_load` is checked to transfer only once.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int CMD_W   = 24;
    localparam int CODE_W  = 16;
    localparam int PD_W    = 2;
    localparam int ENTRY_W = CODE_W + PD_W;

    // field positions fixed by the command format
    localparam int ADDR_LO = 22;
    localparam int LD_LO   = 20;
    localparam int SEL_LO  = 17;
    localparam int BC_BIT  = 18;
    localparam int PDF_BIT = 16;
    localparam int PDM_LO  = 14;

    typedef enum logic [1:0] {
        LM_STORE  = 2'b00,
        LM_SINGLE = 2'b01,
        LM_SIMUL  = 2'b10,
        LM_BCAST  = 2'b11
    } load_mode_e;

    typedef struct packed {
        logic [PD_W-1:0]   pd;
        logic [CODE_W-1:0] code;
    } entry_t;

    localparam logic [PD_W-1:0] PD_NORMAL = '0;
    localparam logic [PD_W-1:0] PD_HIZ    = '1;

endpackage

// File: rtl/dbuf_cmd_decode.sv
module dbuf_cmd_decode
    import dbuf_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_word,
    input  logic [1:0]           addr_strap,
    output logic [NCH-1:0]       wr_tmp,
    output logic [NCH-1:0]       ld_new,
    output logic [NCH-1:0]       cp_tmp,
    output entry_t               new_entry
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    load_mode_e           mode;
    logic                 addr_ok;
    logic                 accept;
    logic [SEL_W-1:0]     sel;
    logic [PD_W-1:0]      pd_req;
    logic                 unused_dc;

    assign unused_dc = cmd_word[19];

    always_comb begin
        mode    = load_mode_e'(cmd_word[LD_LO +: 2]);
        addr_ok = (cmd_word[ADDR_LO +: 2] == addr_strap);
        accept  = cmd_valid && (addr_ok || mode == LM_BCAST);
        sel     = cmd_word[SEL_LO +: SEL_W];

        pd_req = cmd_word[PDM_LO +: PD_W];
        if (!cmd_word[PDF_BIT]) begin
            new_entry.pd = PD_NORMAL;
        end else if (pd_req == PD_NORMAL) begin
            new_entry.pd = PD_HIZ;
        end else begin
            new_entry.pd = pd_req;
        end
        new_entry.code = cmd_word[CODE_W-1:0];

        wr_tmp = '0;
        ld_new = '0;
        cp_tmp = '0;
        for (int i = 0; i < NCH; i++) begin
            if (accept) begin
                unique case (mode)
                    LM_STORE: begin
                        wr_tmp[i] = (sel == SEL_W'(i));
                    end
                    LM_SINGLE: begin
                        wr_tmp[i] = (sel == SEL_W'(i));
                        ld_new[i] = (sel == SEL_W'(i));
                    end
                    LM_SIMUL: begin
                        wr_tmp[i] = (sel == SEL_W'(i));
                        ld_new[i] = (sel == SEL_W'(i));
                        cp_tmp[i] = (sel != SEL_W'(i));
                    end
                    LM_BCAST: begin
                        wr_tmp[i] = cmd_word[BC_BIT];
                        ld_new[i] = cmd_word[BC_BIT];
                        cp_tmp[i] = !cmd_word[BC_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dbuf_edge_det.sv
module dbuf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
        rise      = level_in && !st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dbuf_chan_slot.sv
module dbuf_chan_slot
    import dbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_tmp,
    input  logic               ld_new,
    input  logic               cp_tmp,
    input  entry_t             new_entry,
    output logic [CODE_W-1:0]  code,
    output logic [PD_W-1:0]    pdmode,
    output logic               off
);
    typedef struct packed {
        entry_t stage;
        entry_t live;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_tmp) begin
            st_d.stage = new_entry;
        end
        if (ld_new) begin
            st_d.live = new_entry;
        end else if (cp_tmp) begin
            st_d.live = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code   = st_q.live.code;
    assign pdmode = st_q.live.pd;
    assign off    = |st_q.live.pd;

endmodule

// File: rtl/dbuf_chan_bank.sv
module dbuf_chan_bank
    import dbuf_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr_strap,
    input  logic                  cmd_valid,
    input  logic [CMD_W-1:0]      cmd_word,
    input  logic                  hw_load,
    output logic [NCH*CODE_W-1:0] ch_code,
    output logic [NCH*PD_W-1:0]   ch_pdmode,
    output logic [NCH-1:0]        ch_off
);
    logic [NCH-1:0] dec_wr;
    logic [NCH-1:0] dec_ld;
    logic [NCH-1:0] dec_cp;
    entry_t         dec_entry;
    logic           load_rise;

    dbuf_cmd_decode #(.NCH(NCH)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .addr_strap (addr_strap),
        .wr_tmp     (dec_wr),
        .ld_new     (dec_ld),
        .cp_tmp     (dec_cp),
        .new_entry  (dec_entry)
    );

    dbuf_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (hw_load),
        .rise     (load_rise)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        dbuf_chan_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_tmp    (dec_wr[g]),
            .ld_new    (dec_ld[g]),
            .cp_tmp    (dec_cp[g] | load_rise),
            .new_entry (dec_entry),
            .code      (ch_code[g*CODE_W +: CODE_W]),
            .pdmode    (ch_pdmode[g*PD_W +: PD_W]),
            .off       (ch_off[g])
        );
    end

endmodule

// File: rtl/dbuf_chan_bank_chk.sv
module dbuf_chan_bank_chk
    import dbuf_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            addr_strap,
    input logic                  cmd_valid,
    input logic [CMD_W-1:0]      cmd_word,
    input logic                  hw_load,
    input logic [NCH*CODE_W-1:0] ch_code,
    input logic [NCH*PD_W-1:0]   ch_pdmode
);
    logic       hw_seen_q;
    logic       rise_c;
    logic [1:0] mode_c;
    logic       match_c;
    logic       unused_bits;

    assign unused_bits = cmd_word[19];
    assign rise_c  = hw_load && !hw_seen_q;
    assign mode_c  = cmd_word[21:20];
    assign match_c = (cmd_word[23:22] == addr_strap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hw_seen_q <= 1'b0;
        else        hw_seen_q <= hw_load;
    end

    AST_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && mode_c != 2'b11 && !match_c && !rise_c)
        |=> ($stable(ch_code) && $stable(ch_pdmode))); // R2

    AST_STORE_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && mode_c == 2'b00 && !rise_c)
        |=> ($stable(ch_code) && $stable(ch_pdmode))); // R3

    AST_IDLE_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !rise_c)
        |=> ($stable(ch_code) && $stable(ch_pdmode))); // R10

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        AST_SINGLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode_c == 2'b01 && match_c && !cmd_word[16]
             && cmd_word[18:17] == 2'(g))
            |=> (ch_code[g*CODE_W +: CODE_W] == $past(cmd_word[15:0])
                 && ch_pdmode[g*PD_W +: PD_W] == 2'b00)); // R4

        AST_BCAST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && mode_c == 2'b11 && cmd_word[18])
            |=> (ch_code[g*CODE_W +: CODE_W] == $past(cmd_word[15:0]))); // R7
    end

endmodule

bind dbuf_chan_bank dbuf_chan_bank_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strap (addr_strap),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .hw_load    (hw_load),
    .ch_code    (ch_code),
    .ch_pdmode  (ch_pdmode)
);

// File: tb/dbuf_chan_bank_bench.sv
module dbuf_chan_bank_bench;
    localparam int NCH = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          addr_strap = 2'b00;
    logic                cmd_valid = 1'b0;
    logic [23:0]         cmd_word = '0;
    logic                hw_load = 1'b0;
    logic [NCH*16-1:0]   ch_code;
    logic [NCH*2-1:0]    ch_pdmode;
    logic [NCH-1:0]      ch_off;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [17:0] m_tmp [NCH];
    logic [17:0] m_out [NCH];

    always #10 clk = ~clk;

    dbuf_chan_bank #(.NCH(NCH)) u_dbuf_chan_bank (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .hw_load(hw_load), .ch_code(ch_code),
        .ch_pdmode(ch_pdmode), .ch_off(ch_off)
    );

    function automatic logic [17:0] word_entry(input logic [23:0] w);
        if (w[16]) return {(w[15:14] == 2'b00) ? 2'b11 : w[15:14], w[15:0]};
        return {2'b00, w[15:0]};
    endfunction

    function automatic logic [23:0] mk(input logic [1:0] a, input logic [1:0] m,
                                       input logic [1:0] c, input logic pdf,
                                       input logic [15:0] d);
        return {a, m, 1'b0, c, pdf, d};
    endfunction

    task automatic model_step(input logic [23:0] w, input bit vld, input bit rise);
        logic [17:0] nv;
        logic [17:0] old_tmp [NCH];
        bit hit;
        nv  = word_entry(w);
        hit = vld && (w[21:20] == 2'b11 || w[23:22] == addr_strap);
        for (int i = 0; i < NCH; i++) old_tmp[i] = m_tmp[i];
        for (int i = 0; i < NCH; i++) begin
            bit sel, wt, ldn, cp;
            sel = (w[18:17] == 2'(i));
            wt = 0; ldn = 0; cp = rise;
            if (hit) begin
                case (w[21:20])
                    2'b00: wt = sel;
                    2'b01: begin wt = sel; ldn = sel; end
                    2'b10: begin wt = sel; ldn = sel; cp = cp | !sel; end
                    default: if (w[18]) begin wt = 1; ldn = 1; end else cp = 1;
                endcase
            end
            if (wt) m_tmp[i] = nv;
            if (ldn) m_out[i] = nv;
            else if (cp) m_out[i] = old_tmp[i];
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NCH; i++) begin
            logic [17:0] act;
            bit exp_off;
            act = {ch_pdmode[i*2 +: 2], ch_code[i*16 +: 16]};
            exp_off = (m_out[i][17:16] != 2'b00);
            checks++;
            if (act !== m_out[i] || ch_off[i] !== exp_off) begin
                errors++;
                $display("FAIL %s ch%0d: actual %h off %b, expected %h off %b",
                         tag, i, act, ch_off[i], m_out[i], exp_off);
            end
        end
    endtask

    task automatic send(input logic [23:0] w, input bit rise, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        hw_load   = rise;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        hw_load   = 1'b0;
        model_step(w, 1'b1, rise);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        for (int i = 0; i < NCH; i++) begin m_tmp[i] = '0; m_out[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        addr_strap = 2'b10;
        send(mk(2'b10, 2'b01, 2'd2, 1'b0, 16'h1234), 0, "R4");
        send(mk(2'b01, 2'b01, 2'd1, 1'b0, 16'hDEAD), 0, "R2");
        send(mk(2'b10, 2'b00, 2'd0, 1'b0, 16'hABCD), 0, "R3");
        send(mk(2'b10, 2'b10, 2'd1, 1'b0, 16'h5555), 0, "R5");
        send(mk(2'b10, 2'b01, 2'd3, 1'b1, 16'h4321), 0, "R8");
        send(mk(2'b10, 2'b01, 2'd3, 1'b1, 16'h3FFF), 0, "R8");
        send(mk(2'b10, 2'b01, 2'd3, 1'b1, 16'hBEEF), 0, "R8");
        send(mk(2'b10, 2'b01, 2'd3, 1'b0, 16'hC0DE), 0, "R9");
        send(mk(2'b10, 2'b01, 2'd0, 1'b0, 16'h7777) | 24'h080000, 0, "R12");

        addr_strap = 2'b00;
        send(mk(2'b00, 2'b00, 2'd2, 1'b1, 16'h8001), 0, "R3");
        send(mk(2'b01, 2'b11, 2'd0, 1'b0, 16'h0000), 0, "R6");
        send(mk(2'b10, 2'b11, 2'd2, 1'b0, 16'h9999), 0, "R7");

        send(mk(2'b00, 2'b00, 2'd0, 1'b0, 16'h0A0A), 0, "R3");
        send(mk(2'b00, 2'b00, 2'd1, 1'b1, 16'h8B0B), 0, "R3");
        @(negedge clk);
        hw_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_step(24'h0, 1'b0, 1'b1);
        check_all("R10");
        cmd_valid = 1'b1;
        cmd_word  = mk(2'b00, 2'b00, 2'd0, 1'b0, 16'h0C0C);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        model_step(cmd_word, 1'b1, 1'b0);
        check_all("R10");
        repeat (2) @(negedge clk);
        check_all("R10");
        hw_load = 1'b0;

        send(mk(2'b00, 2'b00, 2'd1, 1'b0, 16'h0D0D), 1, "R11");
        send(mk(2'b00, 2'b01, 2'd2, 1'b0, 16'h0E0E), 1, "R11");

        k = 0;
        for (int s = 0; s < 4; s++) begin
            addr_strap = 2'(s);
            for (int a = 0; a < 4; a++)
                for (int m = 0; m < 4; m++)
                    for (int c = 0; c < 4; c++)
                        for (int p = 0; p < 3; p++) begin
                            logic [15:0] d;
                            logic [23:0] w;
                            bit rise;
                            string tag;
                            d = 16'(s * 4099 + a * 977 + m * 311 + c * 53 + p * 7919 + k * 13);
                            if (p == 2) d[15:14] = 2'b00;
                            w = mk(2'(a), 2'(m), 2'(c), p != 0, d);
                            w[19] = k[0];
                            rise = ((k % 7) == 3);
                            if (rise) tag = "R11";
                            else if (m != 3 && a != s) tag = "R2";
                            else if (m == 0) tag = "R3";
                            else if (m == 1) tag = "R4";
                            else if (m == 2) tag = "R5";
                            else if (c[1]) tag = "R7";
                            else tag = "R6";
                            send(w, rise, tag);
                            k++;
                        end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule